// File: doc/BRIEF.md
# Clock Divider with Phase Offset

This block divides a fast input clock by a programmable integer ratio from 1 to 32. The divided output can be started with a chosen phase. The divide and phase settings are captured by a synchronization strobe. After the strobe is released, the divider waits a programmable number of input clock cycles before it produces its first rising output edge. Several instances that share the clock and the strobe can therefore be given fixed output-to-output delays, in steps of one input clock period.

Even ratios give a 50% duty cycle. For an odd ratio N, the output is high for floor(N/2) input cycles of every N. The phase word is taken modulo the ratio, so an offset equal to the ratio lines up with an offset of zero. A running flag marks the divider as active from its first output edge onwards.

Top module: `clk_div_phase`

## Requirements
- R1: The output period is N input clock cycles. N is the divide setting (1 to 31), and a setting of 0 selects N = 32.
- R2: For an even N, the output is high for N/2 input cycles of each period.
- R3: For an odd N of 3 or more, the output is high for floor(N/2) input cycles of each period, and the high phase comes first.
- R4: The last rising clock edge with sync sampled high is the capture edge. With an effective offset d, the output first goes high at the (d+1)-th rising edge after the capture edge.
- R5: The effective offset d is the 4-bit phase word modulo N. A word equal to N behaves like 0, and a word of 15 with N = 4 behaves like 3.
- R6: The running flag rises at the same clock edge as the first rising output edge after sync. It then stays high until sync or reset.
- R7: While sync or reset is asserted, the output and the running flag are low. After reset, both stay low until a sync pulse has been seen.
- R8: Changes to the divide or phase inputs while sync is low have no effect on the output until the next sync.
- R9: With N = 1, the output follows the input clock while the running flag is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous reset, active high |
| sync | input | 1 | Synchronization strobe; captures settings and restarts the divider |
| div_sel | input | 5 | Divide ratio, 0 means 32 |
| phase_sel | input | 4 | Start offset in input clock cycles |
| clk_out | output | 1 | Divided clock |
| running | output | 1 | High once the first output edge after sync has been produced |

## Verification
The bench aims at the following corner cases:
- **Odd ratios.** An off-by-one in the high count would show 50% on odd ratios or lose a cycle.
- **Offset wrap.** Offsets at and above the ratio are tested. A design that skipped the modulo would start late.
- **Divide setting 0.** A design that mapped 0 to something other than 32 would give the wrong period.
- **Ratio 1.** At ratio 1 the output must be the clock itself and not a constant.
- **Settings changed mid-run.** A divider that read its inputs live would change period without a sync.
- **Sync and reset.** Sync is held for several cycles and reset is applied mid-run. A design that kept running through them would show stray edges or a premature running flag.

// File: rtl/clk_div_phase.sv
module clk_div_phase #(
  parameter int DIV_W = 5,
  parameter int PH_W  = 4
) (
  input  logic             clk_in,
  input  logic             rst,
  input  logic             sync,
  input  logic [DIV_W-1:0] div_sel,
  input  logic [PH_W-1:0]  phase_sel,
  output logic             clk_out,
  output logic             running
);
  localparam int CNT_W = DIV_W + 1;
  localparam logic [CNT_W-1:0] N_MAX = CNT_W'(1 << DIV_W);

  logic [CNT_W-1:0] n_req, d_req, n_r, wcnt, pcnt, pnext, hi;
  logic armed, active, q;

  assign n_req = (div_sel == '0) ? N_MAX : CNT_W'(div_sel);
  assign d_req = CNT_W'(phase_sel) % n_req;
  assign hi    = n_r >> 1;
  assign pnext = (pcnt == n_r - 1'b1) ? '0 : pcnt + 1'b1;

  always_ff @(posedge clk_in) begin
    if (rst) begin
      armed  <= 1'b0;
      active <= 1'b0;
      q      <= 1'b0;
      n_r    <= N_MAX;
      wcnt   <= '0;
      pcnt   <= '0;
    end else if (sync) begin
      armed  <= 1'b1;
      active <= 1'b0;
      q      <= 1'b0;
      n_r    <= n_req;
      wcnt   <= d_req;
      pcnt   <= '0;
    end else if (armed && !active) begin
      if (wcnt == '0) begin
        active <= 1'b1;
        pcnt   <= '0;
        q      <= 1'b1;
      end else begin
        wcnt <= wcnt - 1'b1;
      end
    end else if (active) begin
      pcnt <= pnext;
      q    <= (pnext < hi);
    end
  end

  assign running = active;
  assign clk_out = ~rst & ~sync & ((n_r == CNT_W'(1)) ? (clk_in & active) : q);

  AST_PHASE_IN_RANGE: assert property (@(posedge clk_in) disable iff (rst)
    active |-> (pcnt < n_r)); // R1
  AST_WAIT_WRAPPED: assert property (@(posedge clk_in) disable iff (rst)
    (armed && !active) |-> (wcnt < n_r)); // R5
  AST_FIRST_EDGE_HIGH: assert property (@(posedge clk_in) disable iff (rst)
    ($rose(running) && n_r != CNT_W'(1)) |-> q); // R6
  AST_SYNC_STOPS: assert property (@(posedge clk_in) disable iff (rst)
    sync |=> !running); // R7
  AST_HELD_SETTINGS: assert property (@(posedge clk_in) disable iff (rst)
    !sync |=> $stable(n_r)); // R8
endmodule

// File: tb/clk_div_phase_tb.sv
module clk_div_phase_tb;
  logic clk = 1'b0, rst = 1'b1, sync = 1'b0;
  logic [4:0] div = 5'd4;
  logic [3:0] ph = 4'd0;
  logic clk_out, running;
  int checks = 0, fails = 0, cyc = 0;
  string req = "R7";
  bit done = 1'b0;
  bit m_armed = 1'b0;
  int mN = 32, md = 0, mk = 0;

  always #10 clk = ~clk;

  clk_div_phase u_dut (
    .clk_in(clk), .rst(rst), .sync(sync), .div_sel(div), .phase_sel(ph),
    .clk_out(clk_out), .running(running)
  );

  task automatic step();
    logic e_out, e_run;
    @(posedge clk);
    cyc++;
    if (rst) m_armed = 1'b0;
    else if (sync) begin
      m_armed = 1'b1;
      mN = (div == 0) ? 32 : int'(div);
      md = int'(ph) % mN;
      mk = 0;
    end else if (m_armed) mk++;
    #5;
    if (rst || sync || !m_armed || mk < 1 + md) begin
      e_out = 1'b0; e_run = 1'b0;
    end else begin
      int m;
      m = (mk - 1 - md) % mN;
      e_run = 1'b1;
      e_out = (mN == 1) ? 1'b1 : (m < mN / 2);
    end
    checks++;
    if (clk_out !== e_out || running !== e_run) begin
      fails++;
      $display("FAIL %s cycle %0d: clk_out=%b running=%b expected clk_out=%b running=%b",
               req, cyc, clk_out, running, e_out, e_run);
    end
  endtask

  task automatic run(string r, int d, int p, int n);
    req = r;
    @(negedge clk);
    div = 5'(d); ph = 4'(p); sync = 1'b1;
    step();
    @(negedge clk);
    sync = 1'b0;
    repeat (n) step();
  endtask

  initial begin
    repeat (3) step();                // R7 reset hold
    @(negedge clk); rst = 1'b0;
    repeat (5) step();                // R7 idle until first sync
    for (int p = 0; p < 4; p++) run("R4", 4, p, 20);
    run("R5", 4, 4, 16);              // wraps to 0
    run("R5", 4, 15, 16);             // wraps to 3
    run("R5", 9, 12, 30);             // wraps to 3
    run("R3", 3, 0, 15);
    run("R3", 5, 2, 20);
    run("R3", 7, 1, 25);
    run("R3", 9, 0, 30);
    run("R3", 15, 5, 40);
    run("R3", 31, 15, 70);
    run("R2", 2, 1, 12);
    run("R2", 6, 3, 20);
    run("R1", 0, 7, 80);              // setting 0 selects 32
    run("R9", 1, 9, 10);              // ratio 1 passes the clock
    run("R6", 8, 6, 30);
    req = "R8";                       // live input changes ignored
    @(negedge clk); div = 5'd3; ph = 4'd7;
    repeat (30) step();
    req = "R7";                       // sync held for several cycles
    @(negedge clk); div = 5'd5; ph = 4'd1; sync = 1'b1;
    repeat (4) step();
    @(negedge clk); sync = 1'b0;
    repeat (20) step();
    @(negedge clk); rst = 1'b1;       // reset mid-run
    repeat (3) step();
    @(negedge clk); rst = 1'b0;
    repeat (10) step();
    run("R1", 10, 0, 30);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule